// File: doc/BRIEF.md
# Shared-Address Configuration Register with Read-Armed Write Steering

This block is an 8-bit configuration register that lives at the same I/O offset as a write-only byte counter. A read of that offset, with the first page selected, returns the configuration byte. A write to that offset goes into the configuration register only when the access just before it was a read of the same offset. Otherwise the write is passed on to the counter's high byte as a one-cycle write strobe with its data. Older software that never reads the offset first therefore keeps programming the counter as before. A driver that knows about the configuration register reads the offset and then writes it.

The register holds a two-bit media selection and a wait-timing selection bit. A read also reports the live link state and the bus-error flag from the wait-state logic. The block drives a coaxial transceiver enable that is decoded from the media selection. When automatic detection is selected, that enable follows an external detect input. Idle cycles with no strobe leave the armed state unchanged. Any bus access other than a read of the shared offset removes it.

Top module: `cfg_alias_reg`

## Requirements
- R1: During and after synchronous reset the media field is 2'b11, the timing bit is 0, the armed state is clear, read data is 0, the counter write strobe is 0 and the coax enable is 0.
- R2: A read (rd_stb=1, wr_stb=0) with page 0 and address 0xB makes rd_data equal, on the next cycle, to: bits 1:0 media field, bit 2 link input, bit 3 zero, bit 4 timing bit, bit 5 bus-error input, bits 7:6 zero. The link and bus-error values are those sampled in the read cycle.
- R3: A write to page 0 / address 0xB whose previous access (idle cycles between are allowed) was a read of page 0 / address 0xB loads data bits 1:0 into the media field and data bit 4 into the timing bit on the next cycle. It raises no counter strobe.
- R4: A write to page 0 / address 0xB without such a preceding read leaves the configuration unchanged. On the next cycle it pulses cnt_hi_wr_o for one cycle with cnt_hi_data_o equal to the written byte.
- R5: A write that consumes the arming clears it, so a second write right after goes to the counter.
- R6: Any access other than a read of page 0 / address 0xB, including reads of other offsets or pages and writes anywhere, clears the armed state.
- R7: Bits 2 and 5 cannot be written. Reserved bits 3, 6 and 7 read as 0 whatever was written.
- R8: coax_en_o is 1 for media code 01 and 0 for codes 00 and 10. For code 11 it equals media_det_i. The output is registered, one cycle behind the media field and the detect input.
- R9: A cycle with both rd_stb and wr_stb set is not an access to either register. It changes no register, raises no strobe and clears the armed state.
- R10: rd_data is 0 in every cycle that does not directly follow a read of page 0 / address 0xB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_i | input | PAGE_W | Register page select |
| addr_i | input | ADDR_W | Register offset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| link_ok_i | input | 1 | Link good status |
| bus_err_i | input | 1 | Bus-error flag from the wait-state logic |
| media_det_i | input | 1 | External media detection result, used in auto mode |
| media_sel_o | output | 2 | Media selection field |
| wait_sel_o | output | 1 | Wait-timing selection bit |
| coax_en_o | output | 1 | Coaxial transceiver enable |
| cnt_hi_wr_o | output | 1 | Write strobe toward the aliased counter high byte |
| cnt_hi_data_o | output | 8 | Data for the aliased counter high byte |

## Verification
The properties check on every clock three things that can be stated cycle by cycle: how a shared-offset write is steered by the armed state, that the arming is lost on any non-arming access, and that the readback layout and coax decode match the field contents and inputs one cycle earlier. Only the bench's scenarios can show that whole sequences behave as the software sees them. These are read-then-write programming, legacy writes with no read before them, a second write after a consumed arming, arming broken by reads of other pages or offsets, and the auto-detect coax behaviour over all four media codes. A long random mix of accesses aimed mostly at the shared offset exercises arming across idle gaps against a bench-side model.

// File: rtl/cfg_alias_pkg.sv
package cfg_alias_pkg;
  localparam int CFG_W = 8;

  // bit positions that software decodes
  localparam int MEDIA_LSB = 0;
  localparam int LINK_BIT  = 2;
  localparam int WAIT_BIT  = 4;
  localparam int BERR_BIT  = 5;

  typedef enum logic [1:0] {
    MEDIA_TWISTED = 2'b00,
    MEDIA_THIN    = 2'b01,
    MEDIA_THICK   = 2'b10,
    MEDIA_AUTO    = 2'b11
  } media_e;

  typedef struct packed {
    logic cfg_rd;
    logic cfg_wr;
    logic cnt_wr;
  } steer_t;

  function automatic logic coax_decode(input media_e m, input logic det);
    case (m)
      MEDIA_THIN: coax_decode = 1'b1;
      MEDIA_AUTO: coax_decode = det;
      default:    coax_decode = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alias_arm_ctrl.sv
module alias_arm_ctrl
  import cfg_alias_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PAGE_W   = 2,
  parameter int CFG_ADDR = 11,
  parameter int CFG_PAGE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output steer_t            steer,
  output logic              armed_q
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);
  localparam logic [PAGE_W-1:0] HIT_PAGE = PAGE_W'(CFG_PAGE);

  logic hit, rd_only, wr_only, any_acc;

  always_comb begin
    hit          = (addr_i == HIT_ADDR) && (page_i == HIT_PAGE);
    rd_only      = rd_stb && !wr_stb;
    wr_only      = wr_stb && !rd_stb;
    any_acc      = rd_stb || wr_stb;
    steer.cfg_rd = rd_only && hit;
    steer.cfg_wr = wr_only && hit && armed_q;
    steer.cnt_wr = wr_only && hit && !armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (any_acc) armed_q <= steer.cfg_rd;
  end
endmodule

// File: rtl/cfg_field_store.sv
module cfg_field_store
  import cfg_alias_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             media_det_i,
  output media_e           media_q,
  output logic             wait_q,
  output logic             coax_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      media_q <= MEDIA_AUTO;
      wait_q  <= 1'b0;
      coax_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        media_q <= media_e'(wr_data[MEDIA_LSB +: 2]);
        wait_q  <= wr_data[WAIT_BIT];
      end
      coax_q <= coax_decode(media_q, media_det_i);
    end
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_alias_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  steer_t           steer,
  input  logic [CFG_W-1:0] wr_data,
  input  media_e           media_q,
  input  logic             wait_q,
  input  logic             link_ok_i,
  input  logic             bus_err_i,
  output logic [CFG_W-1:0] rd_data,
  output logic             cnt_wr_q,
  output logic [CFG_W-1:0] cnt_data_q
);
  logic [CFG_W-1:0] view;

  always_comb begin
    view                      = '0;
    view[MEDIA_LSB +: 2]      = media_q;
    view[LINK_BIT]            = link_ok_i;
    view[WAIT_BIT]            = wait_q;
    view[BERR_BIT]            = bus_err_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      cnt_wr_q   <= 1'b0;
      cnt_data_q <= '0;
    end else begin
      rd_data  <= steer.cfg_rd ? view : '0;
      cnt_wr_q <= steer.cnt_wr;
      if (steer.cnt_wr) cnt_data_q <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_alias_reg.sv
module cfg_alias_reg
  import cfg_alias_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PAGE_W   = 2,
  parameter int CFG_ADDR = 11,
  parameter int CFG_PAGE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              link_ok_i,
  input  logic              bus_err_i,
  input  logic              media_det_i,
  output logic [1:0]        media_sel_o,
  output logic              wait_sel_o,
  output logic              coax_en_o,
  output logic              cnt_hi_wr_o,
  output logic [7:0]        cnt_hi_data_o
);
  steer_t steer;
  logic   armed_q;
  media_e media_q;

  alias_arm_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CFG_ADDR(CFG_ADDR), .CFG_PAGE(CFG_PAGE)
  ) arm_i (
    .clk(clk), .rst(rst), .page_i(page_i), .addr_i(addr_i),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .steer(steer), .armed_q(armed_q)
  );

  cfg_field_store store_i (
    .clk(clk), .rst(rst), .cfg_wr(steer.cfg_wr), .wr_data(wr_data),
    .media_det_i(media_det_i), .media_q(media_q), .wait_q(wait_sel_o),
    .coax_q(coax_en_o)
  );

  cfg_readback rb_i (
    .clk(clk), .rst(rst), .steer(steer), .wr_data(wr_data),
    .media_q(media_q), .wait_q(wait_sel_o), .link_ok_i(link_ok_i),
    .bus_err_i(bus_err_i), .rd_data(rd_data), .cnt_wr_q(cnt_hi_wr_o),
    .cnt_data_q(cnt_hi_data_o)
  );

  assign media_sel_o = media_q;
endmodule

// File: rtl/cfg_alias_chk.sv
module cfg_alias_chk #(
  parameter int ADDR_W   = 4,
  parameter int PAGE_W   = 2,
  parameter int CFG_ADDR = 11,
  parameter int CFG_PAGE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [PAGE_W-1:0] page_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              link_ok_i,
  input logic              bus_err_i,
  input logic              media_det_i,
  input logic [1:0]        media_sel_o,
  input logic              wait_sel_o,
  input logic              coax_en_o,
  input logic              cnt_hi_wr_o,
  input logic              armed_q
);
  logic hit;
  assign hit = (addr_i == ADDR_W'(CFG_ADDR)) && (page_i == PAGE_W'(CFG_PAGE));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (media_sel_o == 2'b11 && !wait_sel_o && !armed_q && !cnt_hi_wr_o));

  // R3
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && hit && armed_q) |=>
      (media_sel_o == $past(wr_data[1:0]) && wait_sel_o == $past(wr_data[4]) && !cnt_hi_wr_o));

  // R4
  cnt_steer_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && hit && !armed_q) |=>
      (cnt_hi_wr_o && $stable(media_sel_o) && $stable(wait_sel_o)));

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_stb || wr_stb) && !(rd_stb && !wr_stb && hit)) |=> !armed_q);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && hit) |=>
      (rd_data[1:0] == $past(media_sel_o) && rd_data[2] == $past(link_ok_i) &&
       rd_data[3] == 1'b0 && rd_data[4] == $past(wait_sel_o) &&
       rd_data[5] == $past(bus_err_i) && rd_data[7:6] == 2'b00));

  // R8
  coax_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (coax_en_o == (($past(media_sel_o) == 2'b01) ||
                            ($past(media_sel_o) == 2'b11 && $past(media_det_i)))));

  // R9
  dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && wr_stb) |=> (!cnt_hi_wr_o && $stable(media_sel_o) && rd_data == 8'h00));
endmodule

bind cfg_alias_reg cfg_alias_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CFG_ADDR(CFG_ADDR), .CFG_PAGE(CFG_PAGE)
) chk_i (
  .clk(clk), .rst(rst), .page_i(page_i), .addr_i(addr_i), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .link_ok_i(link_ok_i),
  .bus_err_i(bus_err_i), .media_det_i(media_det_i), .media_sel_o(media_sel_o),
  .wait_sel_o(wait_sel_o), .coax_en_o(coax_en_o), .cnt_hi_wr_o(cnt_hi_wr_o),
  .armed_q(armed_q)
);

// File: tb/cfg_alias_reg_tb.sv
`timescale 1ns/1ps
module cfg_alias_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] page_i = '0;
  logic [3:0] addr_i = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       link_ok_i = 1'b0, bus_err_i = 1'b0, media_det_i = 1'b0;
  logic [1:0] media_sel_o;
  logic       wait_sel_o, coax_en_o, cnt_hi_wr_o;
  logic [7:0] cnt_hi_data_o;

  int checks = 0, failures = 0;
  logic [1:0] m_media = 2'b11;
  logic       m_wait = 1'b0, m_armed = 1'b0;

  always #2.5 clk = ~clk;

  cfg_alias_reg dut_i (
    .clk(clk), .rst(rst), .page_i(page_i), .addr_i(addr_i), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .link_ok_i(link_ok_i),
    .bus_err_i(bus_err_i), .media_det_i(media_det_i), .media_sel_o(media_sel_o),
    .wait_sel_o(wait_sel_o), .coax_en_o(coax_en_o), .cnt_hi_wr_o(cnt_hi_wr_o),
    .cnt_hi_data_o(cnt_hi_data_o)
  );

  function automatic logic [7:0] exp_view(input logic [1:0] m, input logic w,
                                          input logic lk, input logic be);
    exp_view = {2'b00, be, w, 1'b0, lk, m};
  endfunction

  function automatic logic exp_coax(input logic [1:0] m, input logic det);
    exp_coax = (m == 2'b01) || (m == 2'b11 && det);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive at a falling edge, sample at the next falling edge
  task automatic access(input string req, input logic rd, input logic wr,
                        input logic [1:0] pg, input logic [3:0] ad, input logic [7:0] d);
    logic hitp, rd_hit, cfg_w, cnt_w;
    logic [1:0] old_media;
    logic [7:0] exp_rd;
    @(negedge clk);
    rd_stb = rd; wr_stb = wr; page_i = pg; addr_i = ad; wr_data = d;
    link_ok_i = 1'($urandom); bus_err_i = 1'($urandom); media_det_i = 1'($urandom);
    hitp   = (pg == 2'd0) && (ad == 4'hB);
    rd_hit = rd && !wr && hitp;
    cfg_w  = wr && !rd && hitp && m_armed;
    cnt_w  = wr && !rd && hitp && !m_armed;
    exp_rd = rd_hit ? exp_view(m_media, m_wait, link_ok_i, bus_err_i) : 8'h00;
    old_media = m_media;
    if (cfg_w) begin m_media = d[1:0]; m_wait = d[4]; end
    if (rd || wr) m_armed = rd_hit;
    @(negedge clk);
    check({req, " rd_data"}, rd_data, exp_rd);
    check({req, " media"}, {6'd0, media_sel_o}, {6'd0, m_media});
    check({req, " wait"}, {7'd0, wait_sel_o}, {7'd0, m_wait});
    check({req, " cnt_wr"}, {7'd0, cnt_hi_wr_o}, {7'd0, cnt_w});
    if (cnt_w) check({req, " cnt_data"}, cnt_hi_data_o, d);
    check({req, " coax R8"}, {7'd0, coax_en_o}, {7'd0, exp_coax(old_media, media_det_i)});
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 media", {6'd0, media_sel_o}, 8'h03);
    check("R1 wait", {7'd0, wait_sel_o}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 cnt_wr", {7'd0, cnt_hi_wr_o}, 8'h00);
    check("R1 coax", {7'd0, coax_en_o}, 8'h00);
    rst = 1'b0;

    // R4: write with no read before it goes to the counter; R1 armed clear after reset
    access("R4 legacy", 0, 1, 2'd0, 4'hB, 8'hA5);
    // R2 readback, then R3 armed write
    access("R2 read", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R3 write", 0, 1, 2'd0, 4'hB, 8'hFD);
    // R7: link/bus-error and reserved bits not taken from write
    access("R7 read", 1, 0, 2'd0, 4'hB, 8'h00);
    // R5: consumed arming
    access("R5 arm", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R5 first", 0, 1, 2'd0, 4'hB, 8'h12);
    access("R5 second", 0, 1, 2'd0, 4'hB, 8'h3C);
    // R6: read elsewhere, other page, write elsewhere break the arming
    access("R6 arm", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R6 rd other addr R10", 1, 0, 2'd0, 4'hA, 8'h00);
    access("R6 write", 0, 1, 2'd0, 4'hB, 8'h01);
    access("R6 arm", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R6 rd other page R10", 1, 0, 2'd1, 4'hB, 8'h00);
    access("R6 write", 0, 1, 2'd0, 4'hB, 8'h02);
    access("R6 arm", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R6 wr other addr", 0, 1, 2'd0, 4'h3, 8'h00);
    access("R6 write", 0, 1, 2'd0, 4'hB, 8'h02);
    // R9: both strobes
    access("R9 arm", 1, 0, 2'd0, 4'hB, 8'h00);
    access("R9 both", 1, 1, 2'd0, 4'hB, 8'h11);
    access("R9 write", 0, 1, 2'd0, 4'hB, 8'h22);
    // R8: each media code, both detect values
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 3; r++) begin
        access("R8 arm", 1, 0, 2'd0, 4'hB, 8'h00);
        access("R8 set", 0, 1, 2'd0, 4'hB, {6'd0, 2'(c)});
        access("R8 idle-read", 1, 0, 2'd2, 4'h0, 8'h00);
      end
    end
    // random mix, mostly aimed at the shared offset
    for (int i = 0; i < 3000; i++) begin
      logic rd, wr;
      logic [1:0] pg;
      logic [3:0] ad;
      int k;
      k  = $urandom_range(0, 9);
      rd = (k < 5) || (k == 9);
      wr = (k >= 4);
      pg = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd0;
      ad = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'hB;
      access("R3/R4/R6 random", rd, wr, pg, ad, 8'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule